// File: doc/BRIEF.md
# Programmable Ratio Clock Divider

This block derives a divided clock enable from the system clock. The ratio is held in a bit field of a 32-bit control register that a simple register bus writes and reads. Two parameters place the field: its lowest bit position and its width. Static mode inputs set how the raw field value becomes a divisor. The choices are value plus one, the raw value, a power of two, or a lookup in a built-in table of value/divisor pairs. Zero may be allowed as a bypass.

A newly written ratio is decoded one cycle after the register takes it. It is then held as pending and only takes over at the end of the output period already in progress, so no enable period is ever cut short. A rate-ready flag drops while a ratio is pending and rises again once the new ratio is in force. A field value that cannot be decoded leaves the running divisor untouched and raises an error flag.

An optional masked write mode protects the register. The upper half-word of a write acts as a per-bit enable for the lower half-word, and reads in that mode show zero in the upper half.

Top module: `ratio_clk_divider`

## Requirements
- R1: With modeSel = 0 (plus-one), the divisor is the field value plus one.
- R2: With modeSel = 1 (raw), the divisor is the field value. A zero field with allowZero low is invalid.
- R3: With modeSel = 1 and allowZero high, a zero field selects bypass: divEn is high on every cycle (divide by one).
- R4: With modeSel = 2 (power of two), the divisor is 2 raised to the field value.
- R5: With modeSel = 3 (table), entry k (k = 0..3) maps field value 2k to divisor 3k+2. Entry 4 has divisor 0 and ends the table. A value not matched before the end is invalid.
- R6: The field is bits [7:4] of the register by default (FIELD_SHIFT = 4, FIELD_WIDTH = 4). Bits outside it have no effect on the divisor.
- R7: An invalid field value keeps the previous divisor running and sets ratioErr. The next valid ratio write clears ratioErr.
- R8: divEn is a one-cycle pulse every divisor cycles. A new divisor is applied only at the end of the current period. rateReady is low from the cycle after the write until it is applied.
- R9: With maskedWrite high, a write changes only the low-half bits whose matching bit in regWrData[31:16] is set. The upper half of the register is not written.
- R10: regRdData returns the full register when maskedWrite is low, and zero in bits [31:16] when it is high.
- R11: After reset the register is zero, the divisor is 1, rateReady is 1 and ratioErr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data (upper half is the bit mask in masked mode) |
| regRdData | output | 32 | Register read data |
| modeSel | input | 2 | Divisor encoding: 0 plus-one, 1 raw, 2 power of two, 3 table |
| allowZero | input | 1 | Zero field means bypass in raw mode |
| maskedWrite | input | 1 | Enables half-word masked writes and zeroed upper reads |
| divEn | output | 1 | Divided clock enable pulse |
| rateReady | output | 1 | High when no new ratio is waiting to be applied |
| ratioErr | output | 1 | Last written ratio could not be decoded |

## Verification
The divisor is measured as the spacing of divEn pulses after writes in each of the four encodings. Field values are chosen so that each encoding gives a different period from the others: for example, field 3 gives 4 as plus-one, 8 as a power of two, and is rejected by the table. Invalid codes follow a known good ratio, so a kept divisor shows up as an unchanged period rather than a default one. Writes with ones outside the field, a ratio change mid-period with a long old period, and masked writes that touch and skip the field show the field location, that the pending ratio waits for the period end, and the masking.

// File: rtl/ratio_div_pkg.sv
package ratio_div_pkg;

  localparam int DIV_W = 16;

  typedef enum logic [1:0] {
    MODE_PLUS1 = 2'd0,
    MODE_RAW   = 2'd1,
    MODE_POW2  = 2'd2,
    MODE_TABLE = 2'd3
  } divMode_e;

  typedef struct packed {
    logic             applyReq;
    logic [DIV_W-1:0] newDiv;
  } ctrlStrobe_t;

  // table entry k: field value and divisor; divisor 0 terminates
  function automatic int tblVal(int k);
    return 2 * k;
  endfunction

  function automatic int tblDiv(int k, int len);
    return (k < len) ? (3 * k + 2) : 0;
  endfunction

endpackage

// File: rtl/ratio_div_ctrl.sv
module ratio_div_ctrl
  import ratio_div_pkg::*;
#(
  parameter int FIELD_SHIFT = 4,
  parameter int FIELD_WIDTH = 4,
  parameter int TBL_DEPTH   = 8,
  parameter int TBL_LEN     = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic [1:0]  modeSel,
  input  logic        allowZero,
  input  logic        maskedWrite,
  input  logic        periodEnd,
  output ctrlStrobe_t strobe,
  output logic        rateReady,
  output logic        ratioErr
);

  localparam int HALF = 16;

  logic [31:0]            ctrlReg;
  logic                   wrSeen;
  logic                   pending;
  logic [DIV_W-1:0]       pendDiv;
  logic [FIELD_WIDTH-1:0] fieldVal;
  logic [DIV_W-1:0]       decDiv;
  logic                   decOk;
  logic                   tblEnded;
  logic [HALF-1:0]        wrMask;
  divMode_e               mode;

  assign mode     = divMode_e'(modeSel);
  assign wrMask   = regWrData[31:HALF];
  assign fieldVal = ctrlReg[FIELD_SHIFT +: FIELD_WIDTH];

  // register write path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      wrSeen  <= 1'b0;
    end else begin
      wrSeen <= regWrEn;
      if (regWrEn) begin
        if (maskedWrite)
          ctrlReg[HALF-1:0] <= (ctrlReg[HALF-1:0] & ~wrMask) | (regWrData[HALF-1:0] & wrMask);
        else
          ctrlReg <= regWrData;
      end
    end
  end

  assign regRdData = maskedWrite ? {{HALF{1'b0}}, ctrlReg[HALF-1:0]} : ctrlReg;

  // field decode
  always_comb begin
    decDiv   = DIV_W'(1);
    decOk    = 1'b0;
    tblEnded = 1'b0;
    unique case (mode)
      MODE_PLUS1: begin
        decDiv = DIV_W'(fieldVal) + DIV_W'(1);
        decOk  = 1'b1;
      end
      MODE_RAW: begin
        if (fieldVal == '0) begin
          decDiv = DIV_W'(1);
          decOk  = allowZero;
        end else begin
          decDiv = DIV_W'(fieldVal);
          decOk  = 1'b1;
        end
      end
      MODE_POW2: begin
        if (int'(fieldVal) < DIV_W) begin
          decDiv = DIV_W'(1) << fieldVal;
          decOk  = 1'b1;
        end
      end
      MODE_TABLE: begin
        for (int k = 0; k < TBL_DEPTH; k++) begin
          if (!tblEnded) begin
            if (tblDiv(k, TBL_LEN) == 0) begin
              tblEnded = 1'b1;
            end else if (!decOk && tblVal(k) == int'(fieldVal)) begin
              decDiv = DIV_W'(tblDiv(k, TBL_LEN));
              decOk  = 1'b1;
            end
          end
        end
      end
      default: decOk = 1'b0;
    endcase
  end

  // pending ratio bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      pendDiv   <= DIV_W'(1);
      rateReady <= 1'b1;
      ratioErr  <= 1'b0;
    end else begin
      if (pending && periodEnd) begin
        pending   <= 1'b0;
        rateReady <= 1'b1;
      end
      if (wrSeen) begin
        if (decOk) begin
          pending   <= 1'b1;
          pendDiv   <= decDiv;
          rateReady <= 1'b0;
          ratioErr  <= 1'b0;
        end else begin
          ratioErr  <= 1'b1;
        end
      end
    end
  end

  assign strobe.applyReq = pending;
  assign strobe.newDiv   = pendDiv;

  // R8: ready only drops in response to a captured write
  assert_ready_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rateReady) |-> $past(wrSeen));

  // R7: error flag only rises in response to a captured write
  assert_err_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ratioErr) |-> $past(wrSeen));

  // R9: masked writes leave the upper half-word untouched
  assert_mask_upper_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && maskedWrite) |=> $stable(ctrlReg[31:HALF]));

endmodule

// File: rtl/ratio_div_datapath.sv
module ratio_div_datapath
  import ratio_div_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output logic        periodEnd,
  output logic        divEn
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] activeDiv;

  assign periodEnd = (cnt == activeDiv - DIV_W'(1));
  assign divEn     = periodEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      activeDiv <= DIV_W'(1);
    end else if (periodEnd) begin
      cnt <= '0;
      if (strobe.applyReq)
        activeDiv <= strobe.newDiv;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // R8: divisor changes only at a period boundary
  assert_switch_at_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeDiv) |-> $past(periodEnd));

  // R8: counter stays inside the running period
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    cnt < activeDiv);

  // R7: a rejected ratio never leaves a zero divisor running
  assert_div_nonzero_R7: assert property (@(posedge clk) disable iff (!rstN)
    activeDiv != '0);

endmodule

// File: rtl/ratio_clk_divider.sv
module ratio_clk_divider
  import ratio_div_pkg::*;
#(
  parameter int FIELD_SHIFT = 4,
  parameter int FIELD_WIDTH = 4,
  parameter int TBL_DEPTH   = 8,
  parameter int TBL_LEN     = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic [1:0]  modeSel,
  input  logic        allowZero,
  input  logic        maskedWrite,
  output logic        divEn,
  output logic        rateReady,
  output logic        ratioErr
);

  ctrlStrobe_t strobe;
  logic        periodEnd;

  ratio_div_ctrl #(
    .FIELD_SHIFT(FIELD_SHIFT),
    .FIELD_WIDTH(FIELD_WIDTH),
    .TBL_DEPTH  (TBL_DEPTH),
    .TBL_LEN    (TBL_LEN)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .modeSel    (modeSel),
    .allowZero  (allowZero),
    .maskedWrite(maskedWrite),
    .periodEnd  (periodEnd),
    .strobe     (strobe),
    .rateReady  (rateReady),
    .ratioErr   (ratioErr)
  );

  ratio_div_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .periodEnd(periodEnd),
    .divEn    (divEn)
  );

endmodule

// File: tb/tb_ratio_clk_divider.sv
`timescale 1ns/1ps
module tb_ratio_clk_divider;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [1:0]  modeSel = 2'd0;
  logic        allowZero = 1'b0;
  logic        maskedWrite = 1'b0;
  logic        divEn, rateReady, ratioErr;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  ratio_clk_divider dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .modeSel(modeSel), .allowZero(allowZero),
    .maskedWrite(maskedWrite), .divEn(divEn), .rateReady(rateReady),
    .ratioErr(ratioErr)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        az;
    logic [31:0] data;
    logic [15:0] expDiv;
    logic        expErr;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 32'h0000_0030, 16'd4,  1'b0},  // R1 plus-one 3 -> 4
    '{2'd0, 1'b0, 32'hFFFF_FF0F, 16'd1,  1'b0},  // R6 ones outside field ignored
    '{2'd1, 1'b0, 32'h0000_0050, 16'd5,  1'b0},  // R2 raw 5
    '{2'd1, 1'b0, 32'h0000_0000, 16'd5,  1'b1},  // R2 R7 zero invalid, keep 5
    '{2'd1, 1'b1, 32'h0000_0000, 16'd1,  1'b0},  // R3 bypass
    '{2'd2, 1'b0, 32'h0000_0030, 16'd8,  1'b0},  // R4 2^3
    '{2'd2, 1'b0, 32'h0000_0000, 16'd1,  1'b0},  // R4 2^0
    '{2'd3, 1'b0, 32'h0000_0040, 16'd8,  1'b0},  // R5 value 4 -> 8
    '{2'd3, 1'b0, 32'h0000_0060, 16'd11, 1'b0},  // R5 value 6 -> 11
    '{2'd3, 1'b0, 32'h0000_0010, 16'd11, 1'b1},  // R5 R7 unmatched value
    '{2'd3, 1'b0, 32'h0000_0080, 16'd11, 1'b1},  // R5 value past terminator
    '{2'd0, 1'b0, 32'h0000_00B0, 16'd12, 1'b0}   // R1 plus-one 11 -> 12
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [31:0] d);
    @(negedge clk);
    regWrEn   = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  // cycles between two consecutive divEn pulses
  task automatic measure(output int n);
    int guard;
    guard = 0;
    n = 0;
    while (divEn !== 1'b1 && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    do begin
      @(negedge clk);
      n++;
    end while (divEn !== 1'b1 && n < 500);
  endtask

  task automatic waitReady();
    int guard;
    guard = 0;
    while (rateReady !== 1'b1 && guard < 500) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 read", regRdData, 32'h0);
    chk("R11 rateReady", 32'(rateReady), 32'h1);
    chk("R11 ratioErr", 32'(ratioErr), 32'h0);
    measure(n);
    chk("R11 divisor", 32'(n), 32'd1);

    // vector walk
    for (int i = 0; i < NVEC; i++) begin
      modeSel   = VECS[i].mode;
      allowZero = VECS[i].az;
      regWrite(VECS[i].data);
      repeat (3) @(negedge clk);
      waitReady();
      chk($sformatf("vec%0d ratioErr", i), 32'(ratioErr), 32'(VECS[i].expErr));
      measure(n);
      chk($sformatf("vec%0d divisor", i), 32'(n), 32'(VECS[i].expDiv));
    end

    // R8: ratio change mid-run; old period of 12 completes first
    measure(n);
    regWrEn   = 1'b1;
    regWrData = 32'h0000_0010;
    n = 0;
    do begin
      @(negedge clk);
      if (n == 0) regWrEn = 1'b0;
      n++;
      if (n == 3) chk("R8 rateReady low while pending", 32'(rateReady), 32'h0);
    end while (divEn !== 1'b1 && n < 500);
    chk("R8 old period kept", 32'(n), 32'd12);
    measure(n);
    chk("R8 new period", 32'(n), 32'd2);
    chk("R8 rateReady back", 32'(rateReady), 32'h1);

    // R7: valid write clears error
    modeSel = 2'd1;
    regWrite(32'h0);
    repeat (3) @(negedge clk);
    chk("R7 error set", 32'(ratioErr), 32'h1);
    regWrite(32'h0000_0030);
    repeat (3) @(negedge clk);
    chk("R7 error cleared", 32'(ratioErr), 32'h0);

    // R10 / R9 masked mode
    modeSel = 2'd0;
    regWrite(32'hABCD_0035);
    @(negedge clk);
    chk("R10 full read", regRdData, 32'hABCD_0035);
    maskedWrite = 1'b1;
    @(negedge clk);
    chk("R10 upper zero", regRdData, 32'h0000_0035);
    regWrite(32'h000F_00AC);
    @(negedge clk);
    chk("R9 masked low nibble", regRdData, 32'h0000_003C);
    waitReady();
    measure(n);
    chk("R9 field untouched", 32'(n), 32'd4);
    regWrite(32'h00F0_FF70);
    @(negedge clk);
    chk("R9 masked field", regRdData, 32'h0000_007C);
    repeat (2) @(negedge clk);
    waitReady();
    measure(n);
    chk("R9 new divisor", 32'(n), 32'd8);
    maskedWrite = 1'b0;
    @(negedge clk);
    chk("R9 upper not written", regRdData, 32'hABCD_007C);

    summary();
    $finish;
  end

endmodule